// File: doc/BRIEF.md
# UART Auto-Baud Boot Handshake

This block sits on the serial receive pin of a boot loader. It works out the bit rate of an unknown host before any byte can be decoded. The host sends zero bytes back to back. Each zero byte holds the line low for the start bit and all eight data bits, which is nine bit times without a break. The block times one such low run and divides it by nine, with rounding, to get a per-bit divisor in system clock cycles. The run counts only if its length is close to one of the supported host rates and a high interval of at least one bit time follows it.

Once the divisor is accepted, the block loads it into its own 8N1 transmitter and receiver and sends a single zero byte. This byte tells the host that the rate is now matched. The block then waits for the host to confirm with 0x55. Any other byte, or a frame whose stop bit is low, sends it back to measuring. After a good confirmation the block is locked, and each later byte appears on a data bus with a one-cycle strobe.

Top module: `abaud_boot`

## Requirements
- R1: After reset, measuring_o is 1; adjusted_o, locked_o, error_o and rx_valid_o are 0; txd_o is 1 (idle); divisor_o is 0.
- R2: An accepted low run of L system cycles (counted after the two-flop input synchronizer) gives a divisor of (L+4)/9 in integer arithmetic, that is L/9 rounded to nearest. The divisor appears on divisor_o.
- R3: A low run is accepted only if |L - 9*(CLK_HZ/rate)| <= (9*(CLK_HZ/rate)) >> TOL_SHIFT for some rate in {4800, 9600, 19200}. A run outside all three windows gives a one-cycle error_o pulse, and the block stays in measuring.
- R4: After the low run the line must stay high for more than divisor cycles. A fall that comes earlier gives an error_o pulse, and the new low run is timed from that fall as a fresh measurement.
- R5: The low-run counter saturates at its all-ones value and never wraps, so an overlong low is always rejected.
- R6: On acceptance the block sends exactly one 8N1 frame carrying 0x00 (start bit low, data LSB first, stop bit high), each bit lasting exactly divisor cycles. The low part of txd_o is therefore 9*divisor cycles long. Otherwise txd_o stays high.
- R7: adjusted_o goes high once the stop bit of that frame has finished, and measuring_o is then low. divisor_o does not change while adjusted_o is high.
- R8: A 0x55 frame received while adjusted sets locked_o. That byte is not forwarded: rx_valid_o is never high before lock.
- R9: While adjusted but not locked, a byte other than 0x55, or a frame with a low stop bit, gives an error_o pulse. adjusted_o then clears and measuring_o returns to 1.
- R10: After lock, each frame with a high stop bit puts its byte on rx_data_o with rx_valid_o high for exactly one cycle. Bits are sampled near their midpoints, about half a divisor after the start edge and one divisor apart after that.
- R11: After lock, a frame with a low stop bit gives an error_o pulse and no rx_valid_o strobe, and locked_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial input from the host (asynchronous) |
| txd_o | output | 1 | Serial output to the host, idle high |
| measuring_o | output | 1 | Searching for a calibration low run |
| adjusted_o | output | 1 | Zero byte sent; divisor in use |
| locked_o | output | 1 | Confirmation 0x55 received |
| error_o | output | 1 | One-cycle pulse on a rejected run, a bad confirmation or a framing error |
| divisor_o | output | DIV_W | Cycles per bit in use |
| rx_data_o | output | 8 | Received byte after lock |
| rx_valid_o | output | 1 | One-cycle strobe qualifying rx_data_o |

## Verification
The hardest case to reach is a low run whose counter would wrap back into an acceptable window. This happens if the run is longer than the counter range by exactly one nominal 9600-baud run. The bench holds the input low for that length, so a wrapping counter would accept it and a saturating one must reject it. A second hard case is the restart path. Here a valid-length low run is cut short by an early fall, and the bench then checks that the next run is timed from that fall. The host model also drives rates slightly off nominal and a wrong confirmation byte. It then watches the block return to measuring and recalibrate at a different rate.

// File: rtl/abaud_pkg.sv
package abaud_pkg;

  typedef enum logic [1:0] {
    PH_MEASURE,
    PH_SEND,
    PH_CONFIRM,
    PH_LOCKED
  } phase_e;

  // nearest-integer divide of a low run by nine bit periods
  function automatic int unsigned div_of_low(int unsigned low);
    return (low + 32'd4) / 32'd9;
  endfunction

  // true when the run lies inside the window of one supported rate
  function automatic logic rate_fits(int unsigned low, int unsigned clk_hz,
                                     int unsigned base_rate, int unsigned steps,
                                     int unsigned tol_shift);
    logic hit;
    hit = 1'b0;
    for (int unsigned k = 0; k < steps; k++) begin
      int unsigned nom;
      int unsigned dev;
      nom = 32'd9 * (clk_hz / (base_rate << k));
      dev = (low > nom) ? (low - nom) : (nom - low);
      if (dev <= (nom >> tol_shift)) hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/abaud_meter.sv
module abaud_meter #(
  parameter int unsigned CLK_HZ     = 33_000_000,
  parameter int unsigned BASE_RATE  = 4800,
  parameter int unsigned RATE_STEPS = 3,
  parameter int unsigned TOL_SHIFT  = 4,
  parameter int unsigned CNT_W      = 17,
  parameter int unsigned DIV_W      = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rxd_s_i,
  output logic             done_o,
  output logic             reject_o,
  output logic [DIV_W-1:0] div_o
);
  import abaud_pkg::*;

  typedef enum logic [1:0] {M_WAIT, M_LOW, M_HIGH} meter_e;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  meter_e           ph_q;
  logic             prev_q;
  logic [CNT_W-1:0] low_q;
  logic [DIV_W-1:0] high_q;
  logic [DIV_W-1:0] div_q;
  logic             fall;
  logic             fits;

  assign fall  = prev_q & ~rxd_s_i;
  assign fits  = rate_fits(32'(low_q), CLK_HZ, BASE_RATE, RATE_STEPS, TOL_SHIFT);
  assign div_o = div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= 1'b1;
      ph_q     <= M_WAIT;
      low_q    <= '0;
      high_q   <= '0;
      div_q    <= '0;
      done_o   <= 1'b0;
      reject_o <= 1'b0;
    end else begin
      prev_q   <= rxd_s_i;
      done_o   <= 1'b0;
      reject_o <= 1'b0;
      if (!en_i) begin
        ph_q <= M_WAIT;
      end else begin
        case (ph_q)
          M_WAIT: if (fall) begin
            low_q <= CNT_W'(1);
            ph_q  <= M_LOW;
          end
          M_LOW: if (!rxd_s_i) begin
            if (low_q != CNT_MAX) low_q <= low_q + CNT_W'(1);
          end else if (fits) begin
            div_q  <= DIV_W'(div_of_low(32'(low_q)));
            high_q <= DIV_W'(1);
            ph_q   <= M_HIGH;
          end else begin
            reject_o <= 1'b1;
            ph_q     <= M_WAIT;
          end
          M_HIGH: if (!rxd_s_i) begin
            reject_o <= 1'b1;
            low_q    <= CNT_W'(1);
            ph_q     <= M_LOW;
          end else if (high_q >= div_q) begin
            done_o <= 1'b1;
            ph_q   <= M_WAIT;
          end else begin
            high_q <= high_q + DIV_W'(1);
          end
          default: ph_q <= M_WAIT;
        endcase
      end
    end
  end

endmodule

// File: rtl/abaud_tx.sv
module abaud_tx #(
  parameter int unsigned DIV_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [7:0]       data_i,
  output logic             txd_o,
  output logic             done_o
);
  logic             busy_q;
  logic [9:0]       sh_q;
  logic [3:0]       idx_q;
  logic [DIV_W-1:0] cyc_q;

  assign txd_o = ~busy_q | sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      idx_q  <= '0;
      cyc_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          sh_q   <= {1'b1, data_i, 1'b0};
          idx_q  <= '0;
          cyc_q  <= DIV_W'(1);
        end
      end else if (cyc_q >= div_i) begin
        cyc_q <= DIV_W'(1);
        if (idx_q == 4'd9) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end else begin
          sh_q  <= {1'b1, sh_q[9:1]};
          idx_q <= idx_q + 4'd1;
        end
      end else begin
        cyc_q <= cyc_q + DIV_W'(1);
      end
    end
  end

endmodule

// File: rtl/abaud_rx.sv
module abaud_rx #(
  parameter int unsigned DIV_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rxd_s_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [7:0]       data_o,
  output logic             valid_o,
  output logic             ferr_o
);
  logic             prev_q;
  logic             act_q;
  logic [DIV_W-1:0] cnt_q;
  logic [3:0]       idx_q;
  logic [7:0]       sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b1;
      act_q   <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      prev_q  <= rxd_s_i;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      if (!en_i) begin
        act_q <= 1'b0;
      end else if (!act_q) begin
        if (prev_q && !rxd_s_i) begin
          act_q <= 1'b1;
          cnt_q <= div_i >> 1;
          idx_q <= '0;
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - DIV_W'(1);
      end else begin
        cnt_q <= div_i - DIV_W'(1);
        if (idx_q == 4'd0) begin
          if (rxd_s_i) act_q <= 1'b0;
          else         idx_q <= 4'd1;
        end else if (idx_q == 4'd9) begin
          act_q <= 1'b0;
          if (rxd_s_i) begin
            valid_o <= 1'b1;
            data_o  <= sh_q;
          end else begin
            ferr_o <= 1'b1;
          end
        end else begin
          sh_q  <= {rxd_s_i, sh_q[7:1]};
          idx_q <= idx_q + 4'd1;
        end
      end
    end
  end

endmodule

// File: rtl/abaud_boot.sv
module abaud_boot #(
  parameter int unsigned CLK_HZ     = 33_000_000,
  parameter int unsigned BASE_RATE  = 4800,
  parameter int unsigned RATE_STEPS = 3,
  parameter int unsigned TOL_SHIFT  = 4,
  parameter int unsigned DIV_W      = $clog2(2 * (CLK_HZ / BASE_RATE) + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rxd_i,
  output logic             txd_o,
  output logic             measuring_o,
  output logic             adjusted_o,
  output logic             locked_o,
  output logic             error_o,
  output logic [DIV_W-1:0] divisor_o,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o
);
  import abaud_pkg::*;

  localparam int unsigned CNT_W   = $clog2(2 * 9 * (CLK_HZ / BASE_RATE) + 1);
  localparam logic [7:0]  CONFIRM = 8'h55;

  logic [1:0]       sync_q;
  logic             rxd_s;
  phase_e           ph_q;
  logic [DIV_W-1:0] div_q;
  logic             tx_start_q;
  // internal events brought out for the checker
  logic             meas_done;
  logic             meas_reject;
  logic [DIV_W-1:0] meas_div;
  logic             tx_done;
  logic             rx_valid;
  logic             rx_ferr;
  logic [7:0]       rx_byte;

  assign rxd_s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  abaud_meter #(
    .CLK_HZ(CLK_HZ), .BASE_RATE(BASE_RATE), .RATE_STEPS(RATE_STEPS),
    .TOL_SHIFT(TOL_SHIFT), .CNT_W(CNT_W), .DIV_W(DIV_W)
  ) meter_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ph_q == PH_MEASURE), .rxd_s_i(rxd_s),
    .done_o(meas_done), .reject_o(meas_reject), .div_o(meas_div)
  );

  abaud_tx #(.DIV_W(DIV_W)) tx_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(tx_start_q), .div_i(div_q),
    .data_i(8'h00), .txd_o(txd_o), .done_o(tx_done)
  );

  abaud_rx #(.DIV_W(DIV_W)) rx_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .en_i((ph_q == PH_CONFIRM) || (ph_q == PH_LOCKED)),
    .rxd_s_i(rxd_s), .div_i(div_q),
    .data_o(rx_byte), .valid_o(rx_valid), .ferr_o(rx_ferr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= PH_MEASURE;
      div_q      <= '0;
      tx_start_q <= 1'b0;
      error_o    <= 1'b0;
    end else begin
      tx_start_q <= 1'b0;
      error_o    <= 1'b0;
      case (ph_q)
        PH_MEASURE: begin
          if (meas_reject) error_o <= 1'b1;
          if (meas_done) begin
            div_q      <= meas_div;
            tx_start_q <= 1'b1;
            ph_q       <= PH_SEND;
          end
        end
        PH_SEND: if (tx_done) ph_q <= PH_CONFIRM;
        PH_CONFIRM: begin
          if (rx_ferr || (rx_valid && rx_byte != CONFIRM)) begin
            error_o <= 1'b1;
            ph_q    <= PH_MEASURE;
          end else if (rx_valid) begin
            ph_q <= PH_LOCKED;
          end
        end
        PH_LOCKED: if (rx_ferr) error_o <= 1'b1;
        default: ph_q <= PH_MEASURE;
      endcase
    end
  end

  assign measuring_o = (ph_q == PH_MEASURE);
  assign adjusted_o  = (ph_q == PH_CONFIRM) || (ph_q == PH_LOCKED);
  assign locked_o    = (ph_q == PH_LOCKED);
  assign divisor_o   = div_q;
  assign rx_data_o   = rx_byte;
  assign rx_valid_o  = rx_valid && (ph_q == PH_LOCKED);

endmodule

// File: rtl/abaud_boot_chk.sv
module abaud_boot_chk #(
  parameter int unsigned DIV_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             txd_o,
  input logic             measuring_o,
  input logic             adjusted_o,
  input logic             locked_o,
  input logic             error_o,
  input logic             rx_valid_o,
  input logic [DIV_W-1:0] divisor_o,
  input logic             meas_done,
  input logic             meas_reject,
  input logic             tx_done
);
  // R6
  idle_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    measuring_o |-> txd_o);

  // R8
  valid_after_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> locked_o);

  // R10
  one_cycle_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  // R7
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adjusted_o && $past(adjusted_o)) |-> $stable(divisor_o));

  // R8
  lock_from_adjust_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(adjusted_o));

  // R3
  reject_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_reject |=> (error_o && measuring_o));

  // R7
  frame_end_adjust_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done |=> (adjusted_o && txd_o));

  // R2
  accept_leaves_meas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_done |=> !measuring_o);

  // R7
  lock_implies_adjust_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> adjusted_o);
endmodule

bind abaud_boot abaud_boot_chk #(.DIV_W(DIV_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .txd_o(txd_o), .measuring_o(measuring_o),
  .adjusted_o(adjusted_o), .locked_o(locked_o), .error_o(error_o),
  .rx_valid_o(rx_valid_o), .divisor_o(divisor_o), .meas_done(meas_done),
  .meas_reject(meas_reject), .tx_done(tx_done)
);

// File: tb/abaud_boot_tb_top.sv
`timescale 1ns/1ps
module abaud_boot_tb_top;
  localparam int unsigned CLK_HZ = 192_000;
  localparam int unsigned DIV_W  = $clog2(2 * (CLK_HZ / 4800) + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rxd = 1'b1;
  logic             txd, measuring, adjusted, locked, err;
  logic [DIV_W-1:0] divisor;
  logic [7:0]       rx_data;
  logic             rx_valid;

  int checks = 0;
  int errors = 0;
  int err_cnt = 0;
  int valid_cnt = 0;
  int inv_fail = 0;
  logic [7:0] last_data = 8'h00;
  logic prev_valid = 1'b0;

  always #2.5 clk = ~clk;

  abaud_boot #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .txd_o(txd),
    .measuring_o(measuring), .adjusted_o(adjusted), .locked_o(locked),
    .error_o(err), .divisor_o(divisor), .rx_data_o(rx_data), .rx_valid_o(rx_valid)
  );

  // per-clock comparison against the expected status rules
  always @(negedge clk) begin
    if (rst_n) begin
      if (err) err_cnt++;
      if (rx_valid) begin valid_cnt++; last_data = rx_data; end
      if (rx_valid && prev_valid) inv_fail++;
      if (locked && !adjusted) inv_fail++;
      if (measuring && (adjusted || !txd)) inv_fail++;
      if (rx_valid && !locked) inv_fail++;
    end
    prev_valid = rx_valid;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int n);
    rxd = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input int n, input logic stop);
    hold(1'b0, n);
    for (int i = 0; i < 8; i++) hold(b[i], n);
    hold(stop, n);
    hold(1'b1, n);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rxd = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // time one low run, then watch the adjustment-complete frame
  task automatic calibrate(input int low, input int exp_div, input string req);
    int t = 0;
    int run = 0;
    hold(1'b0, low);
    rxd = 1'b1;
    while (txd && t < 3000) begin @(negedge clk); t++; end
    check(!txd, {req, " tx frame starts"}, int'(txd), 0);
    check(divisor == DIV_W'(exp_div), {req, " divisor"}, int'(divisor), exp_div);
    while (!txd && run < 5000) begin run++; @(negedge clk); end
    check(run == 9 * exp_div, "R6 zero-byte low run", run, 9 * exp_div);
    repeat (exp_div + 3) @(negedge clk);
    check(adjusted && !measuring, "R7 adjusted after frame", int'(adjusted), 1);
  endtask

  initial begin
    int e0;
    int v0;
    do_reset();
    // R1 reset state
    check(measuring == 1'b1, "R1 measuring", int'(measuring), 1);
    check(!adjusted && !locked, "R1 adjusted/locked", int'({adjusted, locked}), 0);
    check(txd == 1'b1 && !err && !rx_valid, "R1 txd/err/valid", int'({txd, err, rx_valid}), 4);
    check(divisor == '0, "R1 divisor", int'(divisor), 0);

    // 9600 bps: 20 cycles per bit
    e0 = err_cnt;
    calibrate(180, 20, "R2 9600");
    check(err_cnt == e0, "R3 in-range accepted", err_cnt - e0, 0);
    v0 = valid_cnt;
    send_byte(8'h55, 20, 1'b1);
    check(locked == 1'b1, "R8 locked on 0x55", int'(locked), 1);
    check(valid_cnt == v0, "R8 confirm not forwarded", valid_cnt - v0, 0);
    send_byte(8'hA3, 20, 1'b1);
    check(valid_cnt == v0 + 1 && last_data == 8'hA3, "R10 byte A3", int'(last_data), 'hA3);
    send_byte(8'h3C, 20, 1'b1);
    check(valid_cnt == v0 + 2 && last_data == 8'h3C, "R10 byte 3C", int'(last_data), 'h3C);
    e0 = err_cnt;
    send_byte(8'h5A, 20, 1'b0);
    check(err_cnt == e0 + 1, "R11 framing error pulse", err_cnt - e0, 1);
    check(valid_cnt == v0 + 2 && locked, "R11 no strobe, still locked", valid_cnt - v0, 2);

    // rejects, restart and recalibration
    do_reset();
    hold(1'b1, 30);
    e0 = err_cnt;
    hold(1'b0, 135);
    hold(1'b1, 60);
    check(err_cnt == e0 + 1 && measuring, "R3 off-rate run rejected", err_cnt - e0, 1);
    check(divisor == '0, "R3 divisor untouched", int'(divisor), 0);
    e0 = err_cnt;
    hold(1'b0, 96);
    hold(1'b1, 60);
    check(err_cnt == e0 + 1 && measuring, "R3 window edge 96 rejected", err_cnt - e0, 1);
    e0 = err_cnt;
    hold(1'b0, 180);
    hold(1'b1, 5);
    calibrate(180, 20, "R4 restart");
    check(err_cnt == e0 + 1, "R4 short high rejected once", err_cnt - e0, 1);
    e0 = err_cnt;
    send_byte(8'h12, 20, 1'b1);
    check(err_cnt == e0 + 1, "R9 wrong confirm error", err_cnt - e0, 1);
    check(measuring && !adjusted && !locked, "R9 back to measuring", int'(measuring), 1);
    calibrate(90, 10, "R2 19200");
    send_byte(8'h55, 10, 1'b1);
    check(locked == 1'b1, "R8 locked at 19200", int'(locked), 1);

    // saturation and an off-nominal 4800 host
    do_reset();
    hold(1'b1, 30);
    e0 = err_cnt;
    hold(1'b0, 1024 + 180);
    hold(1'b1, 60);
    check(err_cnt == e0 + 1 && measuring, "R5 overlong low rejected", err_cnt - e0, 1);
    check(divisor == '0, "R5 no divisor from wrap", int'(divisor), 0);
    calibrate(368, 41, "R2 rounding 4800");
    v0 = valid_cnt;
    send_byte(8'h55, 40, 1'b1);
    check(locked == 1'b1, "R8 locked at 4800", int'(locked), 1);
    send_byte(8'h96, 40, 1'b1);
    check(valid_cnt == v0 + 1 && last_data == 8'h96, "R10 byte 96", int'(last_data), 'h96);

    check(inv_fail == 0, "R6/R7/R8/R10 per-clock status rules", inv_fail, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule